// File: doc/BRIEF.md
# Serial Frame Receiver with Justification

This block takes in framed serial data one bit at a time. A single-cycle bit strobe marks each bit period. A frame-sync input marks the start of a frame. Data arrives most significant bit first. The block samples the data pin and the frame-sync input only on cycles where the strobe is high. A programmable delay of zero, one or two bit periods separates the frame sync from the first data bit.

A frame holds one phase or two phases. Each phase has its own word length, chosen by a 3-bit code, and its own count of words. When a word's last bit arrives, the word is aligned into a 32-bit output register in one of three ways: right-aligned with zero fill, right-aligned with sign extension, or left-aligned with zero fill. A ready flag is then raised. A single-cycle read strobe takes the word and clears the ready flag.

Two error flags are provided. The overrun flag is set when a word completes before the previous one was read. The sync-error flag is set when an unexpected frame sync arrives in the middle of a frame. An option lets the block ignore frame syncs that arrive while a frame is in progress.

Top module: `sfr_receiver`

## Requirements
- R1: While reset is held low at a clock edge, `rx_ready`, `rx_full` and `sync_err` clear to 0 and `rx_data` clears to zero.
- R2: The word-length code gives 8 bits for code 0, 12 for 1, 16 for 2, 20 for 3, 24 for 4, and 32 for 5; codes 6 and 7 also give 32 bits. Bits arrive most significant first.
- R3: A frame starts on a strobe where `fsync_in` is 1. With `cfg_dly` equal to 0, the data bit sampled on that same strobe is the first bit of the word. With 1 or 2, that many strobes pass before the first bit. A value of 3 behaves as 2.
- R4: A words-per-phase value N means N+1 words. With `cfg_dual` set to 0 the frame holds only phase A. With 1, phase B follows phase A, using its own length code and word count. Strobes after the frame ends with `fsync_in` at 0 are ignored. A later frame sync starts a new frame without an error.
- R5: `cfg_just` selects the alignment. Code 0 right-aligns with zero fill. Code 1 right-aligns and copies the word's top bit into all upper bits. Code 2 places the word in the upper bits, with zeros below. Code 3 behaves as code 0.
- R6: When a word completes and `rx_ready` is 0 (or `rd_strobe` is high in that cycle), `rx_data` takes the aligned word and `rx_ready` is 1 from the next cycle on. A `rd_strobe` cycle with no word completing clears `rx_ready` on the next cycle.
- R7: When a word completes while `rx_ready` is 1 and `rd_strobe` is 0, `rx_full` becomes 1 and `rx_data` keeps the older word. A `rd_strobe` clears `rx_full` together with `rx_ready`.
- R8: With `cfg_fs_ignore` set to 0, a frame sync on a strobe while a frame is in progress sets `sync_err`, which stays set until reset. Framing then restarts from that strobe, so the word delivered is the one that starts there.
- R9: With `cfg_fs_ignore` set to 1, a frame sync that arrives during a frame has no effect: the word in progress completes unchanged and `sync_err` stays 0. A frame sync while idle still starts a frame.
- R10: On cycles where `bit_en` is 0, the values of `data_in` and `fsync_in` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-period strobe; inputs sampled only when high |
| fsync_in | input | 1 | Frame sync, active high |
| data_in | input | 1 | Serial data, MSB first |
| cfg_dual | input | 1 | 0: one phase per frame, 1: two phases |
| cfg_wlen_a | input | 3 | Word-length code, phase A |
| cfg_wlen_b | input | 3 | Word-length code, phase B |
| cfg_flen_a | input | FLEN_W | Words in phase A minus one |
| cfg_flen_b | input | FLEN_W | Words in phase B minus one |
| cfg_dly | input | 2 | Data delay in bit periods |
| cfg_fs_ignore | input | 1 | Ignore frame syncs during a frame |
| cfg_just | input | 2 | Alignment mode |
| rd_strobe | input | 1 | Read strobe, clears ready and overrun |
| rx_data | output | 32 | Last accepted aligned word |
| rx_ready | output | 1 | Word waiting to be read |
| rx_full | output | 1 | Overrun: a word was lost while ready was set |
| sync_err | output | 1 | Sticky unexpected-frame-sync flag |

## Verification
The assertions on bit-counter range assume that the configuration inputs hold steady while a frame is in progress. They also assume that a read strobe is a single cycle. The bench changes configuration only after a frame has fully completed and the block is idle, and its read strobes last exactly one cycle. Between bit strobes, the bench drives the opposite data value and a high frame sync. This checks that nothing is sampled outside a strobe.

// File: rtl/sfr_pkg.sv
// Shared types and helpers for the serial frame receiver.
// Assumes a fixed 32-bit receive word.
package sfr_pkg;
    localparam int WORD_W = 32;
    localparam int WLEN_W = 6;

    typedef enum logic [1:0] {
        FR_IDLE   = 2'd0,
        FR_DELAY  = 2'd1,
        FR_ACTIVE = 2'd2
    } fr_state_e;

    typedef enum logic [1:0] {
        JUST_RIGHT_ZERO = 2'd0,
        JUST_RIGHT_SIGN = 2'd1,
        JUST_LEFT_ZERO  = 2'd2,
        JUST_RESERVED   = 2'd3
    } just_e;

    // Map a 3-bit length code to a bit count; codes above 5 give 32.
    function automatic logic [WLEN_W-1:0] wlen_bits(input logic [2:0] code);
        logic [WLEN_W-1:0] n;
        if (code >= 3'd5) n = 6'd32;
        else              n = 6'd8 + {1'b0, code, 2'b00};
        return n;
    endfunction
endpackage

// File: rtl/sfr_framer.sv
// Frame sequencer: tracks delay, bit, word and phase position and
// marks which strobes carry data bits and which bit ends a word.
// Assumes configuration is stable while a frame is running.
module sfr_framer
    import sfr_pkg::*;
#(
    parameter int FLEN_W = 7,
    parameter int BCNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              fsync_in,
    input  logic              cfg_dual,
    input  logic [WLEN_W-1:0] cfg_wlen_a,
    input  logic [WLEN_W-1:0] cfg_wlen_b,
    input  logic [FLEN_W-1:0] cfg_flen_a,
    input  logic [FLEN_W-1:0] cfg_flen_b,
    input  logic [1:0]        cfg_dly,
    input  logic              cfg_fs_ignore,
    output logic              take_bit,
    output logic              word_done,
    output logic [WLEN_W-1:0] cur_wlen,
    output logic              err_pulse
);
    fr_state_e         state;
    logic [1:0]        dly_cnt;
    logic [BCNT_W-1:0] bit_cnt;
    logic [FLEN_W-1:0] word_cnt;
    logic              phase;

    logic              idle;
    logic              start;
    logic [1:0]        dly_eff;
    logic              eff_phase;
    logic [BCNT_W-1:0] eff_bit;
    logic [FLEN_W-1:0] eff_word;
    logic [FLEN_W-1:0] cur_flen;
    logic              last_bit;
    logic              last_word;

    // Decode frame start, effective position and bit/word boundaries.
    always_comb begin
        idle      = (state == FR_IDLE);
        start     = bit_en && fsync_in && (idle || !cfg_fs_ignore);
        err_pulse = start && !idle;
        dly_eff   = (cfg_dly > 2'd2) ? 2'd2 : cfg_dly;
        eff_phase = start ? 1'b0 : phase;
        eff_bit   = start ? '0 : bit_cnt;
        eff_word  = start ? '0 : word_cnt;
        cur_wlen  = eff_phase ? cfg_wlen_b : cfg_wlen_a;
        cur_flen  = eff_phase ? cfg_flen_b : cfg_flen_a;
        if (start)
            take_bit = bit_en && (dly_eff == 2'd0);
        else
            take_bit = bit_en && ((state == FR_ACTIVE) ||
                                  (state == FR_DELAY && dly_cnt == 2'd1));
        last_bit  = ({{(WLEN_W-BCNT_W){1'b0}}, eff_bit} == (cur_wlen - 6'd1));
        last_word = (eff_word == cur_flen);
        word_done = take_bit && last_bit;
    end

    // Advance the frame position on each data strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FR_IDLE;
            dly_cnt  <= '0;
            bit_cnt  <= '0;
            word_cnt <= '0;
            phase    <= 1'b0;
        end else if (take_bit) begin
            if (last_bit) begin
                bit_cnt <= '0;
                if (last_word) begin
                    word_cnt <= '0;
                    if (!eff_phase && cfg_dual) begin
                        phase <= 1'b1;
                        state <= FR_ACTIVE;
                    end else begin
                        phase <= 1'b0;
                        state <= FR_IDLE;
                    end
                end else begin
                    word_cnt <= eff_word + 1'b1;
                    phase    <= eff_phase;
                    state    <= FR_ACTIVE;
                end
            end else begin
                bit_cnt  <= eff_bit + 1'b1;
                word_cnt <= eff_word;
                phase    <= eff_phase;
                state    <= FR_ACTIVE;
            end
        end else if (start) begin
            state    <= FR_DELAY;
            dly_cnt  <= dly_eff;
            bit_cnt  <= '0;
            word_cnt <= '0;
            phase    <= 1'b0;
        end else if (bit_en && state == FR_DELAY) begin
            dly_cnt <= dly_cnt - 2'd1;
        end
    end

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(state) && $stable(bit_cnt) && $stable(word_cnt)); // R10
    AST_RESTART_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> (state != FR_IDLE)); // R8
    AST_BIT_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_ACTIVE) |->
        ({{(WLEN_W-BCNT_W){1'b0}}, bit_cnt} < (phase ? cfg_wlen_b : cfg_wlen_a))); // R2
    AST_DELAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_DELAY) |-> (dly_cnt != 2'd0) && (dly_cnt <= 2'd2)); // R3
endmodule

// File: rtl/sfr_justify.sv
// Serial shifter and word aligner: collects bits MSB first and places
// the completed word in the 32-bit result per the alignment mode.
// Assumes word length between 8 and 32.
module sfr_justify
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_bit,
    input  logic              data_in,
    input  logic [WLEN_W-1:0] wlen,
    input  logic [1:0]        mode,
    output logic [WORD_W-1:0] word_out
);
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] next_word;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] raw;
    logic [4:0]        msb_idx;
    logic [WLEN_W-1:0] lshift;

    // Shift one sampled bit in per data strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (take_bit) shreg <= next_word;
    end

    // Align the word that includes the bit on the current strobe.
    always_comb begin
        next_word = {shreg[WORD_W-2:0], data_in};
        mask      = (wlen >= 6'd32) ? '1 : ((32'd1 << wlen) - 32'd1);
        raw       = next_word & mask;
        msb_idx   = 5'(wlen - 6'd1);
        lshift    = 6'd32 - wlen;
        unique case (just_e'(mode))
            JUST_RIGHT_SIGN: word_out = raw[msb_idx] ? (raw | ~mask) : raw;
            JUST_LEFT_ZERO:  word_out = raw << lshift;
            default:         word_out = raw;
        endcase
    end
endmodule

// File: rtl/sfr_rx_buffer.sv
// Receive holding register with ready, overrun and sync-error flags.
// Assumes the read strobe is one cycle wide.
module sfr_rx_buffer
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_done,
    input  logic [WORD_W-1:0] word_in,
    input  logic              rd_strobe,
    input  logic              err_pulse,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              rx_full,
    output logic              sync_err
);
    // Accept a completed word or flag an overrun; clear on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_ready <= 1'b0;
            rx_full  <= 1'b0;
        end else if (word_done) begin
            if (rx_ready && !rd_strobe) begin
                rx_full <= 1'b1;
            end else begin
                rx_data  <= word_in;
                rx_ready <= 1'b1;
                rx_full  <= 1'b0;
            end
        end else if (rd_strobe) begin
            rx_ready <= 1'b0;
            rx_full  <= 1'b0;
        end
    end

    // Hold the sync-error flag once set.
    always_ff @(posedge clk) begin
        if (!rst_n)         sync_err <= 1'b0;
        else if (err_pulse) sync_err <= 1'b1;
    end

    AST_FULL_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> rx_ready); // R7
    AST_OVERRUN_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && rx_ready && !rd_strobe) |=> $stable(rx_data) && rx_full); // R7
    AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> rx_ready); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !word_done) |=> !rx_ready && !rx_full); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> sync_err); // R8
endmodule

// File: rtl/sfr_receiver.sv
// Top of the serial frame receiver: decodes length codes and wires the
// framer, shifter/aligner and holding register together.
// Assumes configuration changes only between frames.
module sfr_receiver
    import sfr_pkg::*;
#(
    parameter int FLEN_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              fsync_in,
    input  logic              data_in,
    input  logic              cfg_dual,
    input  logic [2:0]        cfg_wlen_a,
    input  logic [2:0]        cfg_wlen_b,
    input  logic [FLEN_W-1:0] cfg_flen_a,
    input  logic [FLEN_W-1:0] cfg_flen_b,
    input  logic [1:0]        cfg_dly,
    input  logic              cfg_fs_ignore,
    input  logic [1:0]        cfg_just,
    input  logic              rd_strobe,
    output logic [31:0]       rx_data,
    output logic              rx_ready,
    output logic              rx_full,
    output logic              sync_err
);
    localparam int BCNT_W = $clog2(WORD_W);

    logic [WLEN_W-1:0] wlen_a_bits;
    logic [WLEN_W-1:0] wlen_b_bits;
    logic [WLEN_W-1:0] cur_wlen;
    logic              take_bit;
    logic              word_done;
    logic              err_pulse;
    logic [WORD_W-1:0] aligned;

    // Translate both phase length codes to bit counts.
    always_comb begin
        wlen_a_bits = wlen_bits(cfg_wlen_a);
        wlen_b_bits = wlen_bits(cfg_wlen_b);
    end

    sfr_framer #(.FLEN_W(FLEN_W), .BCNT_W(BCNT_W)) framer_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync_in(fsync_in),
        .cfg_dual(cfg_dual), .cfg_wlen_a(wlen_a_bits), .cfg_wlen_b(wlen_b_bits),
        .cfg_flen_a(cfg_flen_a), .cfg_flen_b(cfg_flen_b), .cfg_dly(cfg_dly),
        .cfg_fs_ignore(cfg_fs_ignore), .take_bit(take_bit), .word_done(word_done),
        .cur_wlen(cur_wlen), .err_pulse(err_pulse)
    );

    sfr_justify justify_i (
        .clk(clk), .rst_n(rst_n), .take_bit(take_bit), .data_in(data_in),
        .wlen(cur_wlen), .mode(cfg_just), .word_out(aligned)
    );

    sfr_rx_buffer buffer_i (
        .clk(clk), .rst_n(rst_n), .word_done(word_done), .word_in(aligned),
        .rd_strobe(rd_strobe), .err_pulse(err_pulse), .rx_data(rx_data),
        .rx_ready(rx_ready), .rx_full(rx_full), .sync_err(sync_err)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !rx_ready && !rx_full && !sync_err && (rx_data == '0)); // R1
endmodule

// File: tb/sfr_receiver_tb_top.sv
module sfr_receiver_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0, fsync_in = 1'b0, data_in = 1'b0;
    logic        cfg_dual = 1'b0, cfg_fs_ignore = 1'b0, rd_strobe = 1'b0;
    logic [2:0]  cfg_wlen_a = '0, cfg_wlen_b = '0;
    logic [6:0]  cfg_flen_a = '0, cfg_flen_b = '0;
    logic [1:0]  cfg_dly = '0, cfg_just = '0;
    logic [31:0] rx_data;
    logic        rx_ready, rx_full, sync_err;

    int checks = 0;
    int errors = 0;
    bit qfs[$];
    bit qd[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sfr_receiver dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync_in(fsync_in),
        .data_in(data_in), .cfg_dual(cfg_dual), .cfg_wlen_a(cfg_wlen_a),
        .cfg_wlen_b(cfg_wlen_b), .cfg_flen_a(cfg_flen_a), .cfg_flen_b(cfg_flen_b),
        .cfg_dly(cfg_dly), .cfg_fs_ignore(cfg_fs_ignore), .cfg_just(cfg_just),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_ready(rx_ready),
        .rx_full(rx_full), .sync_err(sync_err)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbits(int code);
        return (code < 5) ? 8 + 4 * code : 32;
    endfunction

    function automatic logic [31:0] expect_word(logic [31:0] v, int n, int mode);
        logic [31:0] m;
        logic [31:0] r;
        m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
        r = v & m;
        if (mode == 1 && r[n-1]) r = r | ~m;
        else if (mode == 2)      r = r << (32 - n);
        return r;
    endfunction

    function automatic logic [31:0] pattern(int k);
        return (32'h9E37_79B9 * (k + 1)) ^ (k << 3);
    endfunction

    task automatic push(bit fs, bit d);
        qfs.push_back(fs);
        qd.push_back(d);
    endtask

    // Start strobes for delay dly; returns whether the next bit carries the sync.
    task automatic push_start(int dly, bit first_bit, output bit fs_pending);
        int de;
        de = (dly > 2) ? 2 : dly;
        if (de == 0) fs_pending = 1'b1;
        else begin
            fs_pending = 1'b0;
            push(1'b1, ~first_bit);
            for (int i = 1; i < de; i++) push(1'b0, ~first_bit);
        end
    endtask

    task automatic push_word(logic [31:0] v, int n, bit fs_first);
        for (int i = n - 1; i >= 0; i--) push((i == n - 1) ? fs_first : 1'b0, v[i]);
    endtask

    // Drive queued strobes; between strobes drive misleading values.
    task automatic play();
        while (qfs.size() > 0) begin
            @(negedge clk);
            bit_en = 1'b1;
            fsync_in = qfs.pop_front();
            data_in = qd.pop_front();
            @(negedge clk);
            bit_en = 1'b0;
            fsync_in = 1'b1;
            data_in = ~data_in;
        end
    endtask

    task automatic do_read();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; bit_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit pend;
        logic [31:0] w;
        logic [31:0] wa [3];
        logic [31:0] wb [2];
        int k;

        // R1: reset state
        do_reset();
        chk("R1 ready", {31'd0, rx_ready}, 32'd0);
        chk("R1 full", {31'd0, rx_full}, 32'd0);
        chk("R1 err", {31'd0, sync_err}, 32'd0);
        chk("R1 data", rx_data, 32'd0);

        // R10: strobe low, inputs toggling
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); fsync_in = i[0]; data_in = i[1];
        end
        @(negedge clk);
        chk("R10 idle ready", {31'd0, rx_ready}, 32'd0);
        chk("R10 idle err", {31'd0, sync_err}, 32'd0);

        // R2 R3 R5 R6: sweep delay x length code x alignment, one word per frame
        k = 0;
        for (int dly = 0; dly < 4; dly++) begin
            for (int code = 0; code < 8; code++) begin
                for (int mode = 0; mode < 4; mode++) begin
                    @(negedge clk);
                    cfg_dly = 2'(dly); cfg_wlen_a = 3'(code); cfg_just = 2'(mode);
                    cfg_dual = 1'b0; cfg_flen_a = '0; cfg_fs_ignore = 1'b0;
                    w = pattern(k);
                    k++;
                    push_start(dly, w[nbits(code)-1], pend);
                    push_word(w, nbits(code), pend);
                    play();
                    chk($sformatf("R2 R3 R5 data dly=%0d code=%0d mode=%0d", dly, code, mode),
                        rx_data, expect_word(w, nbits(code), (mode == 3) ? 0 : mode));
                    chk("R6 ready set", {31'd0, rx_ready}, 32'd1);
                    do_read();
                    chk("R6 ready cleared", {31'd0, rx_ready}, 32'd0);
                end
            end
        end
        chk("R8 no spurious err in sweep", {31'd0, sync_err}, 32'd0);

        // R4: dual phase, 3 words of 8 bits then 2 words of 16 bits
        do_reset();
        @(negedge clk);
        cfg_dual = 1'b1; cfg_wlen_a = 3'd0; cfg_wlen_b = 3'd2;
        cfg_flen_a = 7'd2; cfg_flen_b = 7'd1; cfg_dly = 2'd1; cfg_just = 2'd1;
        for (int i = 0; i < 3; i++) wa[i] = pattern(200 + i);
        for (int i = 0; i < 2; i++) wb[i] = pattern(300 + i);
        push_start(1, 1'b0, pend);
        for (int i = 0; i < 3; i++) begin
            push_word(wa[i], 8, (i == 0) ? pend : 1'b0);
            play();
            chk($sformatf("R4 phase A word %0d", i), rx_data, expect_word(wa[i], 8, 1));
            do_read();
        end
        for (int i = 0; i < 2; i++) begin
            push_word(wb[i], 16, 1'b0);
            play();
            chk($sformatf("R4 phase B word %0d", i), rx_data, expect_word(wb[i], 16, 1));
            do_read();
        end
        push_word(32'hA5A5_5A5A, 20, 1'b0);
        play();
        chk("R4 bits after frame end ignored", {31'd0, rx_ready}, 32'd0);
        w = pattern(400);
        push_start(1, w[7], pend);
        push_word(w, 8, pend);
        play();
        chk("R4 next frame data", rx_data, expect_word(w, 8, 1));
        chk("R4 next frame no error", {31'd0, sync_err}, 32'd0);

        // R7: overrun keeps the first word
        do_reset();
        @(negedge clk);
        cfg_dual = 1'b0; cfg_wlen_a = 3'd0; cfg_flen_a = 7'd1; cfg_dly = 2'd0; cfg_just = 2'd0;
        wa[0] = 32'h0000_00C3; wa[1] = 32'h0000_003C;
        push_word(wa[0], 8, 1'b1);
        push_word(wa[1], 8, 1'b0);
        play();
        chk("R7 full set", {31'd0, rx_full}, 32'd1);
        chk("R7 older word kept", rx_data, 32'h0000_00C3);
        chk("R7 ready still set", {31'd0, rx_ready}, 32'd1);
        do_read();
        chk("R7 read clears full", {31'd0, rx_full}, 32'd0);
        chk("R7 read clears ready", {31'd0, rx_ready}, 32'd0);

        // R8: unexpected sync restarts framing
        do_reset();
        @(negedge clk);
        cfg_wlen_a = 3'd2; cfg_flen_a = 7'd0; cfg_dly = 2'd0; cfg_fs_ignore = 1'b0;
        push_word(32'h0000_FFFF, 5, 1'b1);
        w = 32'h0000_1234;
        push_word(w, 16, 1'b1);
        play();
        chk("R8 sync error set", {31'd0, sync_err}, 32'd1);
        chk("R8 restarted word", rx_data, 32'h0000_1234);
        do_read();
        chk("R8 error sticky", {31'd0, sync_err}, 32'd1);

        // R9: sync during frame ignored
        do_reset();
        @(negedge clk);
        cfg_wlen_a = 3'd2; cfg_flen_a = 7'd0; cfg_dly = 2'd0; cfg_fs_ignore = 1'b1;
        w = 32'h0000_B00F;
        for (int i = 15; i >= 0; i--) push((i == 15) || (i == 10), w[i]);
        play();
        chk("R9 word unaffected", rx_data, 32'h0000_B00F);
        chk("R9 no error", {31'd0, sync_err}, 32'd0);
        chk("R9 ready", {31'd0, rx_ready}, 32'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule